// File: doc/BRIEF.md
# Framed Serial Command Receiver with Chainable Ready

This block accepts 24-bit command frames from a three-wire serial port made of an active-low select, a serial clock and a data line. It runs entirely on a faster system clock. All three serial pins pass through synchronizers, and falling edges of the serial clock are found by comparing successive synchronized samples. A frame has an 8-bit command followed by 16 data bits, and bits arrive most significant first. When the 24th bit has been taken, the block presents the command and data fields in parallel, together with a valid strobe that lasts one cycle.

Several receivers can share the clock and data lines by chaining: the active-low ready output of one receiver drives the select of the next. A receiver uses only the first 24 bits after its select falls. Once it has them, it pulls ready low, so that the following receiver takes the remaining bits. If select is released before 24 bits have arrived, the partial frame is dropped. A configuration input can keep ready high permanently for receivers at the end of a chain, or for receivers used on their own.

Top module: `serial_frame_rx`

## Requirements
- R1: Bits are captured on falling edges of `sclk_i` while `cs_ni` is low, most significant first. The first 8 bits form `frame_cmd_o[7:0]` (first bit in bit 7), and the next 16 bits form `frame_data_o[15:0]` (9th bit in bit 15).
- R2: `frame_valid_o` is high for exactly one system clock cycle per completed frame. It rises on the third rising system clock edge after the 24th falling edge of `sclk_i` at the pins.
- R3: If `cs_ni` rises before 24 bits have arrived, no strobe is produced, `ready_no` stays high and the frame outputs keep their previous values. The next frame is then decoded from its first bit.
- R4: Falling clock edges after the 24th one, up to the release of `cs_ni`, change neither the frame outputs nor the strobe.
- R5: With `ready_en_i` high, `ready_no` goes low in the same cycle as the strobe. It returns high within four system cycles after `cs_ni` rises.
- R6: With `ready_en_i` low, `ready_no` stays high, and frames are still received and strobed.
- R7: The idle level of `sclk_i` while `cs_ni` is high has no effect. Frames decode identically whether the clock idles high or low.
- R8: While `rst_ni` is low, and right after it is released, `ready_no` is high, `frame_valid_o` is low and both frame fields are zero.
- R9: When two receivers are chained through ready, a 48-bit burst delivers the first 24 bits to the first receiver and the next 24 bits to the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, several times faster than the serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial select, active low, asynchronous to clk_i |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| sdi_i | input | 1 | Serial data in |
| ready_en_i | input | 1 | 1 lets ready_no go low after a full frame |
| ready_no | output | 1 | Active-low frame-taken indication, drives the next select in a chain |
| frame_valid_o | output | 1 | One-cycle strobe marking a new frame |
| frame_cmd_o | output | 8 | Command byte of the last complete frame |
| frame_data_o | output | 16 | Data word of the last complete frame |

## Verification
A wrong bit count shows at the ports straight away. If the count is off by one, the strobe moves by one serial bit period, and every captured field is shifted by a bit against the expected value. A completion flag that fails to stay set shows up either as a second strobe or as ready returning high while select is still low, during the extra bits of a long frame. In a chained pair, the same fault also makes the downstream receiver see a wrong frame. A flag or counter that is not cleared by select shows up in the first frame after an aborted one, which then completes early with misaligned fields.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int CMD_W   = 8;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= RST_VAL;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= RST_VAL;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/srx_fall_det.sv
module srx_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign fall_o = lvl_q & ~lvl_i;
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter
  import srx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             bit_i,
  input  logic             strobe_i,
  output logic             done_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] cnt_o,
  output frame_t           frame_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-2:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               done_q;
  logic               valid_q;
  frame_t             frame_q;
  logic [FRAME_W-1:0] next_word;

  assign next_word = {sh_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      frame_q <= '0;
    end else begin
      valid_q <= 1'b0;
      if (cs_n_i) begin
        sh_q   <= '0;
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (strobe_i && !done_q) begin
        sh_q  <= next_word[FRAME_W-2:0];
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          done_q  <= 1'b1;
          valid_q <= 1'b1;
          frame_q <= frame_t'(next_word);
        end
      end
    end
  end

  assign done_o  = done_q;
  assign valid_o = valid_q;
  assign cnt_o   = cnt_q;
  assign frame_o = frame_q;
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              ready_en_i,
  output logic              ready_no,
  output logic              frame_valid_o,
  output logic [CMD_W-1:0]  frame_cmd_o,
  output logic [DATA_W-1:0] frame_data_o
);
  logic [2:0]       pins_s;
  logic             cs_sync;
  logic             sclk_sync;
  logic             sdi_sync;
  logic             sclk_fall;
  logic             frame_done;
  logic [CNT_W-1:0] bit_cnt;
  frame_t           frame;

  // select resets inactive so no frame starts during reset release
  srx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdi_i}),
    .q_o   (pins_s)
  );

  assign {cs_sync, sclk_sync, sdi_sync} = pins_s;

  srx_fall_det u_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sclk_sync),
    .fall_o(sclk_fall)
  );

  srx_shifter u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_n_i  (cs_sync),
    .bit_i   (sdi_sync),
    .strobe_i(sclk_fall),
    .done_o  (frame_done),
    .valid_o (frame_valid_o),
    .cnt_o   (bit_cnt),
    .frame_o (frame)
  );

  assign ready_no     = ~(frame_done & ready_en_i);
  assign frame_cmd_o  = frame.cmd;
  assign frame_data_o = frame.data;
endmodule

// File: rtl/srx_chk.sv
module srx_chk
  import srx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_sync_i,
  input logic [CNT_W-1:0]  bit_cnt_i,
  input logic              done_i,
  input logic              valid_i,
  input logic [CMD_W-1:0]  cmd_i,
  input logic [DATA_W-1:0] data_i,
  input logic              ready_ni,
  input logic              ready_en_i
);
  // R2
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  // R2
  valid_at_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (bit_cnt_i == CNT_W'(FRAME_W)) && done_i);

  // R4
  frame_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> $stable({cmd_i, data_i}));

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_i <= CNT_W'(FRAME_W));

  // R3
  cs_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_sync_i |=> (bit_cnt_i == '0) && !done_i);

  // R6
  ready_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_ni |-> ready_en_i);

  // R5
  ready_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ready_ni) && $past(ready_en_i)) |-> valid_i);
endmodule

bind serial_frame_rx srx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_sync_i (cs_sync),
  .bit_cnt_i (bit_cnt),
  .done_i    (frame_done),
  .valid_i   (frame_valid_o),
  .cmd_i     (frame_cmd_o),
  .data_i    (frame_data_o),
  .ready_ni  (ready_no),
  .ready_en_i(ready_en_i)
);

// File: tb/serial_frame_rx_test.sv
module serial_frame_rx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, en = 1'b1;
  logic rdy_a, rdy_b, val_a, val_b;
  logic [7:0]  cmd_a, cmd_b;
  logic [15:0] dat_a, dat_b;

  int cyc = 0, checks = 0, errors = 0;
  int va_cnt = 0, vb_cnt = 0, va_cyc = 0, fall_cyc = 0;
  bit dbl = 1'b0, pa = 1'b0, pb = 1'b0, finished = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_frame_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .ready_en_i(en), .ready_no(rdy_a), .frame_valid_o(val_a),
    .frame_cmd_o(cmd_a), .frame_data_o(dat_a));

  serial_frame_rx uut_b (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(rdy_a), .sclk_i(sclk), .sdi_i(sdi),
    .ready_en_i(1'b1), .ready_no(rdy_b), .frame_valid_o(val_b),
    .frame_cmd_o(cmd_b), .frame_data_o(dat_b));

  always @(negedge clk) begin
    if (val_a) begin va_cnt++; va_cyc = cyc; if (pa) dbl = 1'b1; end
    if (val_b) begin vb_cnt++; if (pb) dbl = 1'b1; end
    pa = val_a; pb = val_b;
  end

  function automatic logic [7:0] exp_cmd(input logic [71:0] s, input int ofs);
    return s[71-ofs -: 8];
  endfunction

  function automatic logic [15:0] exp_data(input logic [71:0] s, input int ofs);
    return s[63-ofs -: 16];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [71:0] s, input int n, input bit en_v, input bit idle_hi);
    en = en_v;
    sclk = idle_hi;
    repeat (3) @(negedge clk);
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      int h = $urandom_range(2, 4);
      int l = $urandom_range(2, 4);
      sdi = s[71-i];
      sclk = 1'b1;
      repeat (h) @(negedge clk);
      sclk = 1'b0;
      if (i == 23) fall_cyc = cyc;
      repeat (l) @(negedge clk);
      if (i == 23) begin
        repeat (2) @(negedge clk);
        // R5 / R6: ready state after the 24th bit
        chk(rdy_a == !en_v, en_v ? "R5 ready low" : "R6 ready held high", rdy_a, !en_v);
      end
    end
    repeat (2) @(negedge clk);
    sclk = idle_hi;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    // R5: ready released
    chk(rdy_a == 1'b1, "R5 ready released", rdy_a, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_frame(input logic [71:0] s, input int n, input bit en_v, input bit idle_hi);
    int va0 = va_cnt, vb0 = vb_cnt;
    logic [7:0]  c0 = cmd_a;
    logic [15:0] d0 = dat_a;
    send(s, n, en_v, idle_hi);
    if (n >= 24) begin
      // R2 / R4: exactly one strobe even with extra bits
      chk(va_cnt == va0 + 1, "R2/R4 strobe count", va_cnt - va0, 1);
      // R2: latency
      chk(va_cyc - fall_cyc == 3, "R2 latency", va_cyc - fall_cyc, 3);
      // R1 / R7 / R4
      chk(cmd_a == exp_cmd(s, 0), "R1 cmd", cmd_a, exp_cmd(s, 0));
      chk(dat_a == exp_data(s, 0), "R1 data", dat_a, exp_data(s, 0));
    end else begin
      // R3: discarded
      chk(va_cnt == va0, "R3 no strobe", va_cnt - va0, 0);
      chk({cmd_a, dat_a} == {c0, d0}, "R3 frame kept", {cmd_a, dat_a}, {c0, d0});
    end
    if (!(en_v && n >= 48)) begin
      // R9: downstream sees no full frame
      chk(vb_cnt == vb0, "R9 downstream idle", vb_cnt - vb0, 0);
    end else begin
      chk(vb_cnt == vb0 + 1, "R9 downstream strobe", vb_cnt - vb0, 1);
      chk(cmd_b == exp_cmd(s, 24), "R9 downstream cmd", cmd_b, exp_cmd(s, 24));
      chk(dat_b == exp_data(s, 24), "R9 downstream data", dat_b, exp_data(s, 24));
    end
  endtask

  initial begin
    logic [71:0] s;
    void'($urandom(32'h0c0ffee1));
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(rdy_a == 1'b1 && val_a == 1'b0, "R8 ready/valid in reset", {rdy_a, val_a}, 2'b10);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({cmd_a, dat_a} == 24'h0, "R8 frame zero", {cmd_a, dat_a}, 0);
    chk(rdy_a == 1'b1 && val_a == 1'b0, "R8 after release", {rdy_a, val_a}, 2'b10);

    // R1: fixed pattern, clock idle low then idle high (R7)
    run_frame({24'hA51234, 48'h0}, 24, 1'b1, 1'b0);
    run_frame({24'h3CF00F, 48'h0}, 24, 1'b1, 1'b1);
    // R3: aborted frame, then clean recovery
    run_frame({24'hFFFFFF, 48'h0}, 10, 1'b1, 1'b0);
    run_frame({24'h1E8001, 48'h0}, 24, 1'b1, 1'b1);
    run_frame({24'h800000, 48'h0}, 23, 1'b1, 1'b1);
    // R4: extra bits ignored
    run_frame({24'h0F0F0F, 24'hFFFFFF, 24'h0}, 31, 1'b1, 1'b0);
    // R6: ready disabled
    run_frame({24'h6699AA, 24'h123456, 24'h0}, 48, 1'b0, 1'b0);
    // R9: chained pair
    run_frame({24'hC3A55A, 24'h7E0180, 24'h0}, 48, 1'b1, 1'b1);

    for (int k = 0; k < 40; k++) begin
      int kind = $urandom_range(0, 3);
      int n = (kind == 0) ? $urandom_range(1, 23) :
              (kind == 1) ? 24 :
              (kind == 2) ? $urandom_range(25, 40) : 48;
      s = {$urandom, $urandom, $urandom[7:0]};
      run_frame(s, n, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    // R2: strobe never longer than one cycle
    chk(!dbl, "R2 single-cycle strobe", dbl, 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule